// File: doc/BRIEF.md
# APB Requester Bridge

This block is the requester end of an APB4 link. A simple valid/ready command port stands in for the fast system-bus side. Each accepted command becomes one APB transfer to a single attached completer. The block steps through Idle, Setup and Access. It holds address, direction, write data, byte strobes and protection bits steady while the completer inserts wait states. When the transfer finishes, it reports the read data and the error flag on a valid/ready response port.

Only one transfer is ever in flight. A new command can be taken in two places: in Idle, or in the very cycle the completer signals completion. In the second case the next transfer starts its Setup cycle straight away, with no idle cycle between the two transfers.

Top module: `apb_requester`

## Requirements
- R1: The cycle after a command is accepted is a Setup cycle (psel=1, penable=0), and the cycle after any Setup cycle is an Access cycle (psel=1, penable=1); penable is never high while psel is low.
- R2: The block stays in Access until pready is high, for any number of wait cycles, so a completer with N wait states gives exactly N+1 Access cycles.
- R3: paddr, pwrite, pwdata, pstrb and pprot do not change from the Setup cycle through the Access cycle in which pready is high.
- R4: At most one transfer is outstanding: cmd_ready is low from the Setup cycle until the Access cycle in which pready is high.
- R5: In the completion cycle rsp_valid is high and rsp_err equals pslverr; rsp_rdata equals prdata for a read and is 0 for a write.
- R6: A response not taken (rsp_ready low) stays valid with unchanged rsp_rdata and rsp_err until rsp_ready is high; while it waits, cmd_ready stays low and psel stays low.
- R7: If cmd_valid and rsp_ready are both high in the completion cycle, cmd_ready is high and the next cycle is the Setup cycle of the new command. Otherwise the next cycle has psel low.
- R8: During the transfer, paddr, pwrite, pwdata, pstrb and pprot equal the values presented on cmd_addr, cmd_write, cmd_wdata, cmd_strb and cmd_prot when the command was accepted.
- R9: While rst_n is low, psel, penable and rsp_valid are low. A transfer cut off by reset produces no response after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| cmd_strb | input | DW/8 | Byte-lane enables for writes |
| cmd_prot | input | 3 | Protection attributes |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | DW | Read data (0 for writes) |
| rsp_err | output | 1 | Transfer failed |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access phase marker |
| pwrite | output | 1 | Transfer direction |
| paddr | output | AW | Transfer address |
| pwdata | output | DW | Transfer write data |
| pstrb | output | DW/8 | Transfer byte strobes |
| pprot | output | 3 | Transfer protection |
| pready | input | 1 | Completer finishes the Access cycle |
| prdata | input | DW | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The hardest case to reach is a completion cycle that has a second command already waiting. Here the block must skip Idle and start the next Setup cycle at once, and it may do so only if the response is consumed in that same cycle. The bench reaches this case by keeping cmd_valid high and swapping in a second command during the first Setup cycle. It checks cmd_ready in the cycle pready rises and the address in the following cycle. Separately, a sweep over wait counts, direction, error and response stall lengths keeps responses pending while Idle. This drives the path where the response is held and new commands must be refused.

// File: rtl/apb_requester.sv
module apb_requester #(
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [SW-1:0] cmd_strb,
  input  logic [2:0]    cmd_prot,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [AW-1:0] paddr,
  output logic [DW-1:0] pwdata,
  output logic [SW-1:0] pstrb,
  output logic [2:0]    pprot,
  input  logic          pready,
  input  logic [DW-1:0] prdata,
  input  logic          pslverr
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS} phase_t;

  phase_t          phase;
  logic            held_q;
  logic [DW-1:0]   held_data_q;
  logic            held_err_q;

  logic            finish;
  logic            take;
  logic [DW-1:0]   live_data;

  assign finish    = (phase == S_ACCESS) && pready;
  assign cmd_ready = ((phase == S_IDLE) && (!held_q || rsp_ready)) || (finish && rsp_ready);
  assign take      = cmd_valid && cmd_ready;
  assign live_data = pwrite ? '0 : prdata;

  assign psel      = (phase != S_IDLE);
  assign penable   = (phase == S_ACCESS);
  assign rsp_valid = held_q || finish;
  assign rsp_rdata = held_q ? held_data_q : live_data;
  assign rsp_err   = held_q ? held_err_q : pslverr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE;
    end else begin
      unique case (phase)
        S_IDLE:   if (take) phase <= S_SETUP;
        S_SETUP:  phase <= S_ACCESS;
        S_ACCESS: if (pready) phase <= take ? S_SETUP : S_IDLE;
        default:  phase <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrite <= 1'b0;
      paddr  <= '0;
      pwdata <= '0;
      pstrb  <= '0;
      pprot  <= '0;
    end else if (take) begin
      pwrite <= cmd_write;
      paddr  <= cmd_addr;
      pwdata <= cmd_wdata;
      pstrb  <= cmd_strb;
      pprot  <= cmd_prot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_data_q <= '0;
      held_err_q  <= 1'b0;
    end else if (finish && !rsp_ready) begin
      held_q      <= 1'b1;
      held_data_q <= live_data;
      held_err_q  <= pslverr;
    end else if (held_q && rsp_ready) begin
      held_q      <= 1'b0;
    end
  end

endmodule

// File: rtl/apb_requester_chk.sv
module apb_requester_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic [SW-1:0] pstrb,
  input logic [2:0]    pprot,
  input logic          pready
);

  // R1
  setup_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  // R1
  enable_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !(penable && pready)) |=> ($stable(paddr) && $stable(pwrite) &&
      $stable(pwdata) && $stable(pstrb) && $stable(pprot)));

  // R2
  wait_keeps_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (psel && penable));

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !(penable && pready)) |-> !cmd_ready);

  // R6
  response_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R7
  access_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && pready) |=> !penable);

endmodule

bind apb_requester apb_requester_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .pready(pready)
);

// File: tb/sim_apb_requester.sv
module sim_apb_requester;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_strb = '0;
  logic [2:0]    cmd_prot = '0;
  logic          rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          psel, penable, pwrite, pready, pslverr;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic [SW-1:0] pstrb;
  logic [2:0]    pprot;

  int total = 0;
  int bad = 0;
  int wait_cfg = 0;
  logic err_cfg = 1'b0;
  int wcnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_requester #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_strb(cmd_strb), .cmd_prot(cmd_prot), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .pready(pready),
    .prdata(prdata), .pslverr(pslverr)
  );

  function automatic logic [DW-1:0] rd_of(input logic [AW-1:0] a);
    return 32'hC0DE_0000 + 32'(a) * 3;
  endfunction

  assign pready  = penable && (wcnt == wait_cfg);
  assign prdata  = pwrite ? 32'hDEAD_BEEF : rd_of(paddr);
  assign pslverr = penable ? err_cfg : 1'b0;

  always @(posedge clk) begin
    if (!penable || pready) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, input logic [2:0] p, input int waits,
                      input bit e, input int stall);
    int acc;
    logic [DW-1:0] exp_rd;
    exp_rd = w ? '0 : rd_of(a);
    @(negedge clk);
    wait_cfg = waits; err_cfg = e;
    cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_strb = s; cmd_prot = p;
    cmd_valid = 1'b1; rsp_ready = (stall == 0);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = ~a; cmd_wdata = ~d; cmd_strb = ~s; cmd_prot = ~p; cmd_write = ~w;
    #1;
    chk(psel && !penable, "R1 setup", {psel, penable}, 2'b10);
    chk(paddr == a && pwrite == w && pwdata == d && pstrb == s && pprot == p,
        "R8 fields", paddr, a);
    chk(!cmd_ready, "R4 busy", cmd_ready, 0);
    acc = 0;
    forever begin
      @(negedge clk); #1;
      acc++;
      if (!(psel && penable)) begin
        chk(0, "R1 access", {psel, penable}, 2'b11);
        break;
      end
      if (acc == 1 || pready)
        chk(paddr == a && pwdata == d && pstrb == s && pprot == p && pwrite == w,
            "R3 stable", paddr, a);
      if (pready) break;
      chk(!cmd_ready, "R4 busy", cmd_ready, 0);
    end
    chk(acc == waits + 1, "R2 wait count", acc, waits + 1);
    chk(rsp_valid && rsp_rdata == exp_rd && rsp_err == e, "R5 response", rsp_rdata, exp_rd);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid && rsp_rdata == exp_rd && rsp_err == e && !cmd_ready && !psel,
          "R6 held", rsp_rdata, exp_rd);
    end
    if (stall > 0) begin
      @(negedge clk);
      rsp_ready = 1'b1;
      #1;
      chk(rsp_valid && rsp_rdata == exp_rd, "R6 release", rsp_valid, 1);
    end
    @(negedge clk); #1;
    chk(!psel && !rsp_valid, "R7 back to idle", {psel, rsp_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk(!psel && !penable && !rsp_valid, "R9 reset state", {psel, penable, rsp_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int wt = 0; wt < 4; wt++)
      for (int w = 0; w < 2; w++)
        for (int e = 0; e < 2; e++)
          for (int st = 0; st < 3; st++) begin
            int idx = ((wt * 2 + w) * 2 + e) * 3 + st;
            xfer(w[0], AW'(idx * 37 + 5), 32'h1000_0000 + 32'(idx) * 32'h0101,
                 SW'(idx % 16), 3'(idx % 8), wt, e[0], st);
          end

    // R7 back-to-back with a command waiting at completion
    @(negedge clk);
    wait_cfg = 1; err_cfg = 0; rsp_ready = 1'b1;
    cmd_write = 1'b0; cmd_addr = 12'h111; cmd_valid = 1'b1;
    #1;
    chk(cmd_ready, "R7 first accept", cmd_ready, 1);
    @(negedge clk);
    cmd_write = 1'b1; cmd_addr = 12'h222; cmd_wdata = 32'h5555_AAAA; cmd_strb = 4'h9; cmd_prot = 3'd6;
    #1;
    chk(psel && !penable && paddr == 12'h111, "R7 first setup", paddr, 12'h111);
    @(negedge clk); #1;
    chk(!pready && !cmd_ready, "R4 wait busy", cmd_ready, 0);
    @(negedge clk); #1;
    chk(pready && cmd_ready, "R7 accept at completion", cmd_ready, 1);
    chk(rsp_valid && rsp_rdata == rd_of(12'h111), "R5 first read", rsp_rdata, rd_of(12'h111));
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk(psel && !penable && paddr == 12'h222 && pwrite && pstrb == 4'h9 && pprot == 3'd6,
        "R7 direct setup", paddr, 12'h222);
    #1;
    while (!pready) begin @(negedge clk); #1; end
    chk(rsp_valid && rsp_rdata == 0, "R5 write data zero", rsp_rdata, 0);
    @(negedge clk); #1;
    chk(!psel, "R7 idle after", psel, 0);

    // R9 reset during a long wait
    @(negedge clk);
    wait_cfg = 5; cmd_write = 1'b0; cmd_addr = 12'h3C3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!psel && !penable && !rsp_valid, "R9 reset cuts transfer", {psel, penable, rsp_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!psel && !rsp_valid, "R9 discarded", {psel, rsp_valid}, 0);
    end
    xfer(1'b0, 12'h0AB, 32'h0, 4'hF, 3'd1, 0, 1'b0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule